// File: doc/BRIEF.md
# Hardware Return Address Stack

This block holds the return addresses of a small processor core. When the core executes a call or takes an interrupt, it raises a push strobe with the address of the next instruction. When it executes a return, it raises a pop strobe and loads its program counter from the popped address. The storage is separate from program and data memory. A stack pointer selects the current top entry, and two sticky flags record an overflow and an underflow.

Software reaches the stack through a small byte-wide register port. One status register combines the pointer with both flags. Three byte registers expose the entry under the pointer, so a software stack or an operating system can save, restore or rewrite return addresses. A configuration input picks the overflow policy. In one policy the block asks the reset generator to reset the device. In the other it saturates and refuses further pushes. The reset generator is not part of this block. The block only produces a one-cycle request for it.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the pointer is 0, both flags are clear, the status register reads 8'h00, and the reset request is low.
- R2: A push on its own first raises the pointer by one and then stores the push address in the entry the new pointer selects. From the next cycle, pop_addr_o shows that address.
- R3: pop_addr_o always shows the entry under the current pointer, so in a pop cycle it carries the popped address. The pointer then drops by one at the clock edge.
- R4: A mixed sequence of pushes and pops returns the addresses in last-in, first-out order.
- R5: A push made while the pointer is 30 is the push that fills the stack. It stores its address in entry 31 and sets the full flag.
- R6: With cfg_ovf_rst_i high, that filling push also sets the pointer to 0 and drives rst_req_o high for exactly one cycle, starting the cycle after the push. The full flag stays set, and entry 31 keeps the stored address.
- R7: With cfg_ovf_rst_i low, that filling push sets the pointer to 31 and never raises rst_req_o. A push made while the pointer is 31 changes neither the pointer nor entry 31, and it sets the full flag.
- R8: A pop made while the pointer is 0 shows 0 on pop_addr_o, leaves the pointer at 0 and sets the underflow flag.
- R9: Both flags are sticky. A status write holding 0 in a flag's bit clears that flag. A status write holding 1 keeps the flag as it is and never sets it.
- R10: The status register at address 0 holds the full flag in bit 7, the underflow flag in bit 6 and the pointer in bits 4:0, with bit 5 reading 0. Writing it loads the pointer from bits 4:0.
- R11: Addresses 1, 2 and 3 read and write bits 7:0, bits 15:8 and bits 20:16 of the entry under the pointer. The bits 20:16 appear in bits 4:0 of address 3, and bits 7:5 of address 3 read 0. While the pointer is 0, all three addresses read 0 and writes to them are ignored.
- R12: When push and pop are asserted in the same cycle, the push takes effect and the pop is ignored.
- R13: A register write made in the same cycle as a push or a pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| push_i | input | 1 | Push strobe (call or interrupt) |
| push_addr_i | input | 21 | Return address to store |
| pop_i | input | 1 | Pop strobe (return) |
| pop_addr_o | output | 21 | Entry under the pointer, or 0 when the pointer is 0 |
| cfg_ovf_rst_i | input | 1 | 1: overflow requests reset; 0: overflow saturates |
| rst_req_o | output | 1 | One-cycle device reset request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 low, 2 high, 3 upper |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |

## Verification
The bench builds the block with its default parameters: 21-bit addresses and a 5-bit pointer, which give 31 entries. With this depth, both overflow policies take only about thirty pushes to reach. The bench can therefore fill the stack completely and then empty it against its own copy of the expected contents. It also writes the pointer through the status register, so it can check that entry 31 keeps its value after a reset-policy overflow, and that writes to the top-of-stack registers are ignored while the pointer is 0.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    RAS_REG_STATUS = 2'd0,
    RAS_REG_TOS_LO = 2'd1,
    RAS_REG_TOS_HI = 2'd2,
    RAS_REG_TOS_UP = 2'd3
  } ras_reg_e;

  localparam int RAS_FULL_BIT = 7;
  localparam int RAS_UNF_BIT  = 6;
  localparam int RAS_LANES    = 3;

  // Status byte layout: full, underflow, spare zero, 5-bit pointer field.
  function automatic logic [7:0] ras_pack_status(logic full, logic unf, logic [4:0] ptr);
    return {full, unf, 1'b0, ptr};
  endfunction

  // Replace one byte lane of a padded 24-bit entry.
  function automatic logic [23:0] ras_merge_lane(logic [23:0] word, logic [1:0] lane,
                                                 logic [7:0] data);
    logic [23:0] r;
    r = word;
    case (lane)
      2'd0:    r[7:0]   = data;
      2'd1:    r[15:8]  = data;
      default: r[23:16] = data;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl #(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             cfg_ovf_rst_i,
  input  logic             stat_wr_i,
  input  logic [PTR_W-1:0] stat_ptr_i,
  input  logic             stat_keep_full_i,
  input  logic             stat_keep_unf_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] wr_slot_o,
  output logic             full_o,
  output logic             unf_o,
  output logic             rst_req_o,
  output logic             ev_store_o,
  output logic             ev_ovf_o,
  output logic             ev_sat_o,
  output logic             ev_unf_o,
  output logic             ev_stat_o
);
  localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

  logic [PTR_W-1:0] ptr_q;
  logic             full_q, unf_q, rst_req_q;
  logic             do_pop, at_top, at_bot;
  logic [PTR_W-1:0] inc;

  always_comb begin
    do_pop     = pop_i & ~push_i;
    at_top     = (ptr_q == TOP);
    at_bot     = (ptr_q == '0);
    inc        = ptr_q + 1'b1;
    ev_store_o = push_i & ~at_top;
    ev_ovf_o   = ev_store_o & (inc == TOP);
    ev_sat_o   = push_i & at_top;
    ev_unf_o   = do_pop & at_bot;
    ev_stat_o  = stat_wr_i & ~push_i & ~pop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      full_q    <= 1'b0;
      unf_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= ev_ovf_o & cfg_ovf_rst_i;
      if (ev_store_o)
        ptr_q <= (ev_ovf_o && cfg_ovf_rst_i) ? '0 : inc;
      else if (do_pop && !at_bot)
        ptr_q <= ptr_q - 1'b1;
      else if (ev_stat_o)
        ptr_q <= stat_ptr_i;

      if (ev_ovf_o || ev_sat_o)
        full_q <= 1'b1;
      else if (ev_stat_o && !stat_keep_full_i)
        full_q <= 1'b0;

      if (ev_unf_o)
        unf_q <= 1'b1;
      else if (ev_stat_o && !stat_keep_unf_i)
        unf_q <= 1'b0;
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_slot_o = inc;
  assign full_o    = full_q;
  assign unf_o     = unf_q;
  assign rst_req_o = rst_req_q;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  localparam int DEPTH = (1 << PTR_W) - 1;

  logic [ADDR_W-1:0] mem [1:DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= DEPTH; i++) mem[i] <= '0;
    end else if (wr_en_i && wr_idx_i != '0) begin
      mem[wr_idx_i] <= wr_data_i;
    end
  end

  // Slot zero has no storage behind it and reads as zero.
  assign rd_data_o = (rd_idx_i == '0) ? '0 : mem[rd_idx_i];

endmodule

// File: rtl/ras_regport.sv
module ras_regport
  import ras_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              busy_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              full_i,
  input  logic              unf_i,
  input  logic [ADDR_W-1:0] tos_i,
  output logic [7:0]        reg_rdata_o,
  output logic              stat_wr_o,
  output logic              tos_wr_o,
  output logic [ADDR_W-1:0] tos_wdata_o
);
  logic [23:0] tos_pad;
  logic [7:0]  lane_b [RAS_LANES];
  logic [23:0] merged;

  assign tos_pad = 24'(tos_i);

  genvar k;
  generate
    for (k = 0; k < RAS_LANES; k++) begin : g_lane
      assign lane_b[k] = tos_pad[8*k +: 8];
    end
  endgenerate

  always_comb begin
    case (ras_reg_e'(reg_addr_i))
      RAS_REG_STATUS: reg_rdata_o = ras_pack_status(full_i, unf_i, 5'(ptr_i));
      RAS_REG_TOS_LO: reg_rdata_o = lane_b[0];
      RAS_REG_TOS_HI: reg_rdata_o = lane_b[1];
      default:        reg_rdata_o = lane_b[2];
    endcase
    merged      = ras_merge_lane(tos_pad, reg_addr_i - 2'd1, reg_wdata_i);
    tos_wdata_o = merged[ADDR_W-1:0];
    stat_wr_o   = reg_wr_i & (reg_addr_i == RAS_REG_STATUS);
    tos_wr_o    = reg_wr_i & ~busy_i & (reg_addr_i != RAS_REG_STATUS) & (ptr_i != '0);
  end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  input  logic              cfg_ovf_rst_i,
  output logic              rst_req_o,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o
);
  logic [PTR_W-1:0]  sp, wr_slot;
  logic              flag_full, flag_unf;
  logic              ev_store, ev_ovf, ev_sat, ev_unf, ev_stat;
  logic              stat_wr, tos_wr;
  logic [ADDR_W-1:0] tos_word, tos_wdata;
  logic              mem_we;
  logic [PTR_W-1:0]  mem_idx;
  logic [ADDR_W-1:0] mem_wdata;

  ras_ptr_ctrl #(.PTR_W(PTR_W)) u_ptr (
    .clk             (clk),
    .rst_n           (rst_n),
    .push_i          (push_i),
    .pop_i           (pop_i),
    .cfg_ovf_rst_i   (cfg_ovf_rst_i),
    .stat_wr_i       (stat_wr),
    .stat_ptr_i      (reg_wdata_i[PTR_W-1:0]),
    .stat_keep_full_i(reg_wdata_i[RAS_FULL_BIT]),
    .stat_keep_unf_i (reg_wdata_i[RAS_UNF_BIT]),
    .ptr_o           (sp),
    .wr_slot_o       (wr_slot),
    .full_o          (flag_full),
    .unf_o           (flag_unf),
    .rst_req_o       (rst_req_o),
    .ev_store_o      (ev_store),
    .ev_ovf_o        (ev_ovf),
    .ev_sat_o        (ev_sat),
    .ev_unf_o        (ev_unf),
    .ev_stat_o       (ev_stat)
  );

  ras_regport #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .busy_i      (push_i | pop_i),
    .ptr_i       (sp),
    .full_i      (flag_full),
    .unf_i       (flag_unf),
    .tos_i       (tos_word),
    .reg_rdata_o (reg_rdata_o),
    .stat_wr_o   (stat_wr),
    .tos_wr_o    (tos_wr),
    .tos_wdata_o (tos_wdata)
  );

  // A push writes the slot above the pointer; a register write hits the slot under it.
  always_comb begin
    mem_we    = ev_store | tos_wr;
    mem_idx   = ev_store ? wr_slot : sp;
    mem_wdata = ev_store ? push_addr_i : tos_wdata;
  end

  ras_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (mem_we),
    .wr_idx_i  (mem_idx),
    .wr_data_i (mem_wdata),
    .rd_idx_i  (sp),
    .rd_data_o (tos_word)
  );

  assign pop_addr_o = tos_word;

endmodule

// File: rtl/ras_checks.sv
module ras_checks #(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic              cfg_ovf_rst_i,
  input logic [PTR_W-1:0]  sp,
  input logic              flag_full,
  input logic              flag_unf,
  input logic              rst_req_o,
  input logic [ADDR_W-1:0] pop_addr_o,
  input logic              ev_store,
  input logic              ev_ovf,
  input logic              ev_stat,
  input logic [7:0]        reg_wdata_i
);
  localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

  assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store && !ev_ovf |=> sp == ($past(sp) + 1'b1));

  assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && sp != '0 |=> sp == ($past(sp) - 1'b1));

  assert_ovf_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf && cfg_ovf_rst_i |=> sp == '0 && flag_full && rst_req_o);

  assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(ev_ovf && cfg_ovf_rst_i));

  assert_ovf_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf && !cfg_ovf_rst_i |=> sp == TOP && flag_full && !rst_req_o);

  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && sp == TOP |=> sp == TOP && flag_full);

  assert_unf_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && sp == '0 |-> pop_addr_o == '0);

  assert_unf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && sp == '0 |=> flag_unf && sp == '0);

  assert_full_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_full && !(ev_stat && !reg_wdata_i[7]) |=> flag_full);

  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unf && !(ev_stat && !reg_wdata_i[6]) |=> flag_unf);

  assert_push_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop_i && !flag_unf |=> !flag_unf);

endmodule

bind ret_addr_stack ras_checks #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .push_i        (push_i),
  .pop_i         (pop_i),
  .cfg_ovf_rst_i (cfg_ovf_rst_i),
  .sp            (sp),
  .flag_full     (flag_full),
  .flag_unf      (flag_unf),
  .rst_req_o     (rst_req_o),
  .pop_addr_o    (pop_addr_o),
  .ev_store      (ev_store),
  .ev_ovf        (ev_ovf),
  .ev_stat       (ev_stat),
  .reg_wdata_i   (reg_wdata_i)
);

// File: tb/tb_ret_addr_stack.sv
`timescale 1ns/1ps
module tb_ret_addr_stack;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0, cfg_ovf_rst_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] pop_addr_o;
  logic          rst_req_o;
  logic          reg_wr_i = 1'b0;
  logic [1:0]    reg_addr_i = 2'd0;
  logic [7:0]    reg_wdata_i = 8'd0;
  logic [7:0]    reg_rdata_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ret_addr_stack dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .pop_addr_o(pop_addr_o), .cfg_ovf_rst_i(cfg_ovf_rst_i),
    .rst_req_o(rst_req_o), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic push(logic [AW-1:0] a);
    push_i = 1'b1; push_addr_i = a;
    @(negedge clk);
    push_i = 1'b0;
  endtask

  task automatic pop_chk(string tag, logic [AW-1:0] exp);
    pop_i = 1'b1;
    #1;
    chk(tag, 32'(pop_addr_o), 32'(exp));
    @(negedge clk);
    pop_i = 1'b0;
  endtask

  function automatic logic [AW-1:0] val(int i);
    return AW'(32'h0B0B1 * i + 32'h1A34);
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 status", 32'(d), 32'h00);
    chk("R1 rst_req", 32'(rst_req_o), 0);
    rd(2'd1, d); chk("R11 tos at ptr0", 32'(d), 0);
  endtask

  task automatic t_lifo();
    logic [7:0] d;
    logic [AW-1:0] m [1:5];
    for (int i = 1; i <= 5; i++) begin
      m[i] = AW'(32'h0D58 + i * 32'h11111);
      push(m[i]);
      chk("R2 top after push", 32'(pop_addr_o), 32'(m[i]));
    end
    rd(2'd0, d); chk("R10 status ptr", 32'(d), 32'h05);
    rd(2'd2, d); chk("R11 tos high", 32'(d), 32'(m[5][15:8]));
    rd(2'd3, d); chk("R11 tos upper", 32'(d), 32'(m[5][20:16]));
    pop_chk("R3 pop top", m[5]);
    pop_chk("R4 pop order", m[4]);
    push(21'h0ABCDE);
    pop_chk("R4 repush", 21'h0ABCDE);
    for (int i = 3; i >= 1; i--) pop_chk("R4 drain", m[i]);
    rd(2'd0, d); chk("R3 ptr back at zero", 32'(d), 32'h00);
  endtask

  task automatic t_underflow();
    logic [7:0] d;
    pop_chk("R8 pop at zero gives 0", '0);
    rd(2'd0, d); chk("R8 unf set ptr 0", 32'(d), 32'h40);
    wr(2'd0, 8'h40);
    rd(2'd0, d); chk("R9 write 1 keeps", 32'(d), 32'h40);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R9 write 0 clears", 32'(d), 32'h00);
    wr(2'd0, 8'hC0);
    rd(2'd0, d); chk("R9 write 1 never sets", 32'(d), 32'h00);
  endtask

  task automatic t_both_and_conflict();
    logic [7:0] d;
    push(21'h000111);
    push_i = 1'b1; pop_i = 1'b1; push_addr_i = 21'h000222;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    rd(2'd0, d); chk("R12 push wins ptr", 32'(d), 32'h02);
    chk("R12 push wins top", 32'(pop_addr_o), 32'h222);
    reg_wr_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h05;
    push_i = 1'b1; push_addr_i = 21'h000333;
    @(negedge clk);
    push_i = 1'b0; reg_wr_i = 1'b0;
    rd(2'd0, d); chk("R13 status write with push ignored", 32'(d), 32'h03);
    reg_wr_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 8'h55;
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0; reg_wr_i = 1'b0;
    rd(2'd1, d); chk("R13 tos write with pop ignored", 32'(d), 32'h22);
    // Rewrite the top entry byte by byte.
    wr(2'd1, 8'h12); wr(2'd2, 8'h34); wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R11 upper bits 7:5 read 0", 32'(d), 32'h1F);
    chk("R11 merged entry", 32'(pop_addr_o), 32'h1F3412);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h77);
    rd(2'd1, d); chk("R11 read at ptr0", 32'(d), 0);
    wr(2'd0, 8'h01);
    chk("R11 write at ptr0 ignored", 32'(pop_addr_o), 32'h111);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_ovf_sat();
    logic [7:0] d;
    cfg_ovf_rst_i = 1'b0;
    for (int i = 1; i <= 30; i++) push(val(i));
    rd(2'd0, d); chk("R5 no full at 30", 32'(d), 32'h1E);
    push(val(31));
    rd(2'd0, d); chk("R5 R7 full, ptr 31", 32'(d), 32'h9F);
    chk("R7 no reset request", 32'(rst_req_o), 0);
    push(21'h1FFFFF);
    rd(2'd0, d); chk("R7 saturated ptr", 32'(d), 32'h9F);
    chk("R7 entry 31 kept", 32'(pop_addr_o), 32'(val(31)));
    for (int i = 31; i >= 1; i--) pop_chk("R4 full drain", val(i));
    rd(2'd0, d); chk("R9 full sticky after drain", 32'(d), 32'h80);
  endtask

  task automatic t_ovf_rst();
    logic [7:0] d;
    wr(2'd0, 8'h00);
    cfg_ovf_rst_i = 1'b1;
    for (int i = 1; i <= 30; i++) push(val(i + 40));
    chk("R6 no request early", 32'(rst_req_o), 0);
    push(val(71));
    chk("R6 request raised", 32'(rst_req_o), 1);
    rd(2'd0, d); chk("R6 ptr 0, full kept", 32'(d), 32'h80);
    @(negedge clk);
    chk("R6 request one cycle", 32'(rst_req_o), 0);
    wr(2'd0, 8'h9F);
    chk("R6 entry 31 stored", 32'(pop_addr_o), 32'(val(71)));
    rd(2'd1, d); chk("R11 low of entry 31", 32'(d), 32'(val(71)) & 32'hFF);
    cfg_ovf_rst_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lifo();
    t_underflow();
    t_both_and_conflict();
    t_ovf_sat();
    t_ovf_rst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule